// File: doc/BRIEF.md
# Integer Carrier Offset Estimator (Continual-Pilot Correlation)

This block finds the integer part of a carrier frequency offset in an OFDM receiver. It sits after the FFT and takes the subcarriers of each symbol as a stream, one complex value per cycle, with a marker on the first subcarrier of every symbol. Symbols are grouped into pairs. For each pair, the block correlates the first symbol against the second at the continual-pilot positions, which are the same in every symbol. It repeats this over a window of candidate subcarrier shifts and reports the shift with the largest correlation magnitude as a signed integer, together with a one-cycle done pulse.

Each of two banks holds one symbol pair, in two symbol RAMs. While one bank is filled with the next pair, the other bank is read by the correlator, so capture and computation overlap. The pilot positions are a parameter vector that is read like a ROM. Later logic turns the estimate into a bin shift for the frequency correction loop.

Top module: `ifo_estimator`

## Requirements
- R1: A symbol starts at a valid sample with `in_sop` high. That sample and the following valid samples are stored at subcarrier indices 0 to NFFT-1 in order. Valid samples before the first `in_sop`, or after the NFFT-th sample of a symbol and before the next `in_sop`, are ignored.
- R2: Completed symbols form non-overlapping pairs in arrival order. The first symbol of a pair is X1 and the second is X2. Each pair yields exactly one estimate.
- R3: For a candidate shift s, the correlation is C(s) = sum over pilot positions p of X1[p+s]·conj(X2[p+s]). Its real part is Σ(a_re·b_re + a_im·b_im) and its imaginary part is Σ(a_im·b_re − a_re·b_im).
- R4: The magnitude of C(s) is |Re| + |Im|, and the reported shift is the candidate with the largest magnitude.
- R5: The candidates are every integer from −NSHIFT/2 to NSHIFT/2−1. `est_shift` is their two's-complement value, $clog2(NSHIFT) bits wide.
- R6: A term whose index p+s lies below 0 or above NFFT−1 contributes zero. It does not wrap around.
- R7: When magnitudes are equal, the shift with the smaller |s| wins. If |s| is also equal, the negative shift wins.
- R8: Pairs may arrive back to back with no idle cycles. The next pair is captured while the previous one is evaluated, and every pair gets its estimate. This requires NSHIFT·NPILOT + 4 ≤ 2·NFFT.
- R9: `est_valid` is high for exactly one cycle per estimate. `est_shift` keeps its value until the next estimate.
- R10: A synchronous active-high reset clears `est_valid` and `est_shift` to 0 and discards any partly captured pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Subcarrier sample present |
| in_sop | input | 1 | Marks the first subcarrier of a symbol |
| in_re | input | DW | Real part of the subcarrier, signed |
| in_im | input | DW | Imaginary part of the subcarrier, signed |
| est_valid | output | 1 | One-cycle pulse when a new estimate is ready |
| est_shift | output | $clog2(NSHIFT) | Estimated integer offset in subcarriers, signed |

## Verification
The bench builds the block with NFFT=64, four pilots at 1, 17, 30 and 62, NSHIFT=8 and 8-bit samples. At these sizes, pilots near both ends of the symbol meet candidate indices past either edge, so a value placed where a wrapped index would land tells wrapping apart from zeroing. Eight candidates make it easy to build exact ties: one with different |s| and one between mirrored shifts. Short symbols let several pairs run back to back, so capture into one bank overlaps with evaluation of the other.

// File: rtl/ifo_pkg.sv
package ifo_pkg;
  typedef enum logic {SLOT_REF = 1'b0, SLOT_CMP = 1'b1} slot_e;
endpackage

// File: rtl/ifo_sym_ram.sv
module ifo_sym_ram #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ifo_capture.sv
module ifo_capture
  import ifo_pkg::*;
#(
  parameter int NFFT = 1024,
  localparam int IW = $clog2(NFFT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  output logic          wr_en,
  output logic          wr_bank,
  output slot_e         wr_slot,
  output logic [IW-1:0] wr_addr,
  output logic          pair_done,
  output logic          pair_bank
);
  logic          active;
  logic [IW-1:0] idx;
  logic          last;

  assign wr_en   = in_valid && (in_sop || active);
  assign wr_addr = in_sop ? '0 : idx;
  assign last    = wr_en && (wr_addr == IW'(NFFT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      wr_bank   <= 1'b0;
      wr_slot   <= SLOT_REF;
      pair_done <= 1'b0;
      pair_bank <= 1'b0;
    end else begin
      pair_done <= 1'b0;
      if (wr_en) begin
        if (last) begin
          active <= 1'b0;
          idx    <= '0;
          if (wr_slot == SLOT_CMP) begin
            pair_done <= 1'b1;
            pair_bank <= wr_bank;
            wr_bank   <= ~wr_bank;
            wr_slot   <= SLOT_REF;
          end else begin
            wr_slot <= SLOT_CMP;
          end
        end else begin
          active <= 1'b1;
          idx    <= wr_addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ifo_correlator.sv
module ifo_correlator #(
  parameter int NFFT   = 1024,
  parameter int NPILOT = 8,
  parameter int NSHIFT = 16,
  parameter int DW     = 12,
  parameter logic [NPILOT*$clog2(NFFT)-1:0] PILOT_TABLE = '0,
  localparam int IW   = $clog2(NFFT),
  localparam int SW   = $clog2(NSHIFT),
  localparam int PW   = $clog2(NPILOT),
  localparam int PROD = 2*DW + 1,
  localparam int AW   = PROD + PW + 1,
  localparam int MW   = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_bank,
  output logic                 busy,
  output logic                 rd_bank,
  output logic [IW-1:0]        rd_addr,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic                 est_valid,
  output logic [SW-1:0]        est_shift
);
  localparam logic [SW-1:0] S_FIRST = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] S_LAST  = {1'b0, {(SW-1){1'b1}}};

  // issue stage
  logic signed [SW-1:0]   s_cnt;
  logic [PW-1:0]          p_cnt;
  logic [IW-1:0]          pos;
  logic signed [IW+1:0]   idx;
  logic                   in_range, p_last, s_end;

  assign pos      = PILOT_TABLE[p_cnt*IW +: IW];
  assign idx      = $signed({2'b00, pos}) + (IW+2)'(s_cnt);
  assign in_range = (idx >= 0) && (idx < NFFT);
  assign rd_addr  = idx[IW-1:0];
  assign p_last   = (p_cnt == PW'(NPILOT - 1));
  assign s_end    = (s_cnt == S_LAST);

  // accumulate stage
  logic                   v1, last1, fin1, inr1;
  logic signed [SW-1:0]   s1;
  logic signed [AW-1:0]   acc_re, acc_im, acc_re_n, acc_im_n, t_re, t_im;
  logic signed [PROD-1:0] re_t, im_t;
  logic signed [MW-1:0]   e_re, e_im;
  logic [MW-1:0]          mag, best_mag;
  logic signed [SW-1:0]   best_s;
  logic                   best_vld, better;
  logic [SW-1:0]          abs_s1, abs_best;

  assign re_t = PROD'(a_re * b_re) + PROD'(a_im * b_im);
  assign im_t = PROD'(a_im * b_re) - PROD'(a_re * b_im);
  assign t_re = inr1 ? AW'(re_t) : '0;
  assign t_im = inr1 ? AW'(im_t) : '0;
  assign acc_re_n = acc_re + t_re;
  assign acc_im_n = acc_im + t_im;
  assign e_re = MW'(acc_re_n);
  assign e_im = MW'(acc_im_n);
  assign mag  = (e_re[MW-1] ? MW'(-e_re) : MW'(e_re))
              + (e_im[MW-1] ? MW'(-e_im) : MW'(e_im));
  assign abs_s1   = s1[SW-1]     ? SW'(-s1)     : SW'(s1);
  assign abs_best = best_s[SW-1] ? SW'(-best_s) : SW'(best_s);
  // candidates arrive in ascending order, so a strict compare keeps the negative one on |s| ties
  assign better = !best_vld || (mag > best_mag) ||
                  ((mag == best_mag) && (abs_s1 < abs_best));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; rd_bank <= 1'b0;
      s_cnt <= '0; p_cnt <= '0;
      v1 <= 1'b0; last1 <= 1'b0; fin1 <= 1'b0; inr1 <= 1'b0; s1 <= '0;
    end else begin
      v1 <= busy;
      last1 <= busy && p_last;
      fin1  <= busy && p_last && s_end;
      inr1  <= busy && in_range;
      s1    <= s_cnt;
      if (start && !busy) begin
        busy    <= 1'b1;
        rd_bank <= start_bank;
        s_cnt   <= S_FIRST;
        p_cnt   <= '0;
      end else if (busy) begin
        if (p_last) begin
          p_cnt <= '0;
          s_cnt <= s_cnt + 1'b1;
          if (s_end) busy <= 1'b0;
        end else begin
          p_cnt <= p_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_re <= '0; acc_im <= '0;
      best_mag <= '0; best_s <= '0; best_vld <= 1'b0;
      est_valid <= 1'b0; est_shift <= '0;
    end else begin
      est_valid <= 1'b0;
      if (v1) begin
        if (last1) begin
          acc_re <= '0;
          acc_im <= '0;
          if (fin1) begin
            best_vld  <= 1'b0;
            est_valid <= 1'b1;
            est_shift <= better ? s1 : best_s;
          end else if (better) begin
            best_vld <= 1'b1;
            best_mag <= mag;
            best_s   <= s1;
          end
        end else begin
          acc_re <= acc_re_n;
          acc_im <= acc_im_n;
        end
      end
    end
  end
endmodule

// File: rtl/ifo_estimator.sv
module ifo_estimator
  import ifo_pkg::*;
#(
  parameter int NFFT   = 1024,
  parameter int NPILOT = 8,
  parameter int NSHIFT = 16,
  parameter int DW     = 12,
  parameter logic [NPILOT*$clog2(NFFT)-1:0] PILOT_TABLE =
    {10'd1000, 10'd870, 10'd702, 10'd555, 10'd401, 10'd256, 10'd113, 10'd37},
  localparam int IW = $clog2(NFFT),
  localparam int SW = $clog2(NSHIFT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 est_valid,
  output logic [SW-1:0]        est_shift
);
  logic          wr_en, wr_bank, pair_done, pair_bank, busy, rd_bank;
  slot_e         wr_slot;
  logic [IW-1:0] wr_addr, rd_addr;
  logic [2*DW-1:0] rdata [2][2];
  logic [2*DW-1:0] ref_q, cmp_q;

  ifo_capture #(.NFFT(NFFT)) u_capture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_slot(wr_slot), .wr_addr(wr_addr),
    .pair_done(pair_done), .pair_bank(pair_bank)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar t = 0; t < 2; t++) begin : g_slot
      ifo_sym_ram #(.WIDTH(2*DW), .DEPTH(NFFT)) u_ram (
        .clk(clk),
        .we(wr_en && (wr_bank == b[0]) && (wr_slot == slot_e'(t))),
        .waddr(wr_addr), .wdata({in_re, in_im}),
        .raddr(rd_addr), .rdata(rdata[b][t])
      );
    end
  end

  assign ref_q = rdata[rd_bank][0];
  assign cmp_q = rdata[rd_bank][1];

  ifo_correlator #(
    .NFFT(NFFT), .NPILOT(NPILOT), .NSHIFT(NSHIFT), .DW(DW), .PILOT_TABLE(PILOT_TABLE)
  ) u_corr (
    .clk(clk), .rst(rst), .start(pair_done), .start_bank(pair_bank),
    .busy(busy), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .a_re(ref_q[2*DW-1:DW]), .a_im(ref_q[DW-1:0]),
    .b_re(cmp_q[2*DW-1:DW]), .b_im(cmp_q[DW-1:0]),
    .est_valid(est_valid), .est_shift(est_shift)
  );
endmodule

// File: rtl/ifo_estimator_checker.sv
module ifo_estimator_checker #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          est_valid,
  input logic [SW-1:0] est_shift,
  input logic          pair_done,
  input logic          busy
);
  // R9: done is a single-cycle pulse
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    est_valid |=> !est_valid);
  // R9: estimate holds between pulses
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !est_valid |-> $stable(est_shift));
  // R8: a finished pair never finds the correlator still busy
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    pair_done |-> !busy);
  // R2: an estimate only follows a started evaluation
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !est_valid);
  // R10: reset clears the pulse
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> !est_valid);
endmodule

bind ifo_estimator ifo_estimator_checker #(.SW(SW)) u_checker (
  .clk(clk), .rst(rst), .est_valid(est_valid), .est_shift(est_shift),
  .pair_done(pair_done), .busy(busy)
);

// File: tb/ifo_estimator_bench.sv
module ifo_estimator_bench;
  localparam int NFFT = 64, NPILOT = 4, NSHIFT = 8, DW = 8, SW = 3;
  localparam logic [4*6-1:0] PT = {6'd62, 6'd30, 6'd17, 6'd1};
  localparam int PILOTS [4] = '{1, 17, 30, 62};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_sop = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic est_valid;
  logic [SW-1:0] est_shift;

  int errors = 0, checks = 0, pulses = 0, pairs = 0;
  int sym_re [2][NFFT], sym_im [2][NFFT];
  int exp_q [$];
  int tag_q [$];
  int last_exp = 0;
  int unsigned seed = 32'h1234_5678;
  bit done_flag = 0;

  always #10 clk = ~clk;

  ifo_estimator #(.NFFT(NFFT), .NPILOT(NPILOT), .NSHIFT(NSHIFT), .DW(DW), .PILOT_TABLE(PT))
    u_ifo_estimator (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
                     .in_re(in_re), .in_im(in_im), .est_valid(est_valid), .est_shift(est_shift));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference from R3..R7
  function automatic int model();
    longint best_m = -1;
    int best_s = 0;
    for (int s = -NSHIFT/2; s < NSHIFT/2; s++) begin
      longint cre = 0, cim = 0, m;
      for (int p = 0; p < NPILOT; p++) begin
        int k = PILOTS[p] + s;
        if (k >= 0 && k < NFFT) begin            // R6: no wrap
          cre += sym_re[0][k]*sym_re[1][k] + sym_im[0][k]*sym_im[1][k];
          cim += sym_im[0][k]*sym_re[1][k] - sym_re[0][k]*sym_im[1][k];
        end
      end
      m = (cre < 0 ? -cre : cre) + (cim < 0 ? -cim : cim);
      if (m > best_m || (m == best_m && (s < 0 ? -s : s) < (best_s < 0 ? -best_s : best_s))) begin
        best_m = m; best_s = s;
      end
    end
    return best_s;
  endfunction

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % (2*span + 1)) - span;
  endfunction

  task automatic clear_syms();
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < NFFT; k++) begin sym_re[t][k] = 0; sym_im[t][k] = 0; end
  endtask

  task automatic noise_syms(input int span);
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < NFFT; k++) begin sym_re[t][k] = rnd(span); sym_im[t][k] = rnd(span); end
  endtask

  task automatic put(input int k, input int r1, input int i1, input int r2, input int i2);
    sym_re[0][k] = r1; sym_im[0][k] = i1; sym_re[1][k] = r2; sym_im[1][k] = i2;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
    end
  endtask

  task automatic stray(input int n);   // valid samples with no start marker
    repeat (n) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_re = 8'sd100; in_im = -8'sd100;
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic send_pair(input int expv, input int tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    pairs++;
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < NFFT; k++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sop = (k == 0);
        in_re = DW'(sym_re[t][k]); in_im = DW'(sym_im[t][k]);
      end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
  endtask

  // monitor: scoreboard pop on each result
  always @(negedge clk) begin
    if (!rst && est_valid) begin
      pulses++;
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected estimate", $signed(est_shift), 0);
      else begin
        int e, tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        last_exp = e;
        check(int'($signed(est_shift)) == e, $sformatf("R%0d estimate", tg), $signed(est_shift), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(est_valid == 1'b0, "R10 reset est_valid", est_valid, 0);
    check(est_shift == '0, "R10 reset est_shift", est_shift, 0);

    // R1: samples before the first start marker are ignored
    stray(20);

    // R4: clear peak at +2
    clear_syms();
    for (int p = 0; p < NPILOT; p++) put(PILOTS[p] + 2, 20, 5, 18, 6);
    send_pair(model(), 4);
    check(model() == 2, "R4 model peak", model(), 2);
    // R1: extra samples after a complete symbol are dropped
    stray(15);
    idle(60);

    // R3: rotated second symbol, peak at -3
    clear_syms();
    for (int p = 0; p < NPILOT; p++) if (PILOTS[p] - 3 >= 0) put(PILOTS[p] - 3, 30, -10, 10, 30);
    send_pair(model(), 3);
    idle(60);

    // R7: all-zero data, every candidate ties, 0 wins
    clear_syms();
    send_pair(0, 7);
    idle(60);

    // R7: tie between -3 and +1, smaller |s| wins
    clear_syms();
    put(17 - 3, 10, 0, 10, 0);
    put(17 + 1, 10, 0, 10, 0);
    send_pair(1, 7);
    idle(60);

    // R7: tie between -2 and +2, negative wins
    clear_syms();
    put(30 - 2, 0, 9, 0, 9);
    put(30 + 2, 0, 9, 0, 9);
    send_pair(-2, 7);
    idle(60);

    // R6: index 0 reached by s=-1 legally, and by s=+2 only by wrapping from 62
    clear_syms();
    put(0, 10, 0, 10, 0);
    put(19, 5, 0, 5, 0);
    send_pair(-1, 6);
    idle(60);

    // R5: peak at the lowest candidate -4
    clear_syms();
    for (int p = 0; p < NPILOT; p++) if (PILOTS[p] - 4 >= 0) put(PILOTS[p] - 4, 25, 25, 25, 25);
    send_pair(-4, 5);

    // R8: back-to-back pairs of noisy data with a planted peak
    for (int n = 0; n < 4; n++) begin
      noise_syms(6);
      for (int p = 0; p < NPILOT; p++) if (PILOTS[p] + n - 1 < NFFT) put(PILOTS[p] + n - 1, 60, -40, 55, -45);
      send_pair(model(), 8);
    end

    // R3: pure noise pair
    noise_syms(40);
    send_pair(model(), 3);

    idle(200);
    check(exp_q.size() == 0, "R2 all estimates delivered", exp_q.size(), 0);
    check(pulses == pairs, "R2 one pulse per pair", pulses, pairs);
    idle(30);
    check(int'($signed(est_shift)) == last_exp, "R9 estimate held", $signed(est_shift), last_exp);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule